// File: doc/BRIEF.md
# Background Radix Estimator for a Dual-Channel Converter Stage

This block tracks the effective inter-stage gain ("radix") of one converter stage while conversion carries on without pause. The stage is built twice, and the two copies see the same analog input with opposite sign. Each copy has a ±1 calibration bit injected at its stage. The back-end codes of both copies are added, which removes the input signal. What is left in the sum is each channel's injected term scaled by its true radix, plus noise.

For each channel, the block subtracts its own current estimate times its calibration bit from the sum. It then looks at the sign of the residual times the calibration bit. On every valid sample, each estimate moves up or down by one fixed least-significant step, or holds when the product is zero.

A sample counter raises a completion flag once a set number of valid samples has been processed. The counter can be restarted. The estimates themselves never stop tracking. Two maximal-length shift registers supply the calibration bits for the analog side.

Top module: `radix_corr_est`

## Requirements
- R1: After reset both estimates equal INIT_EST (default 0x0200_0000, i.e. 2.0 with 24 fractional bits), `done` is 0, and both generated calibration bits are 0.
- R2: While `valid` is 0, neither estimate, the sample count, nor either generated calibration bit changes.
- R3: Codes are signed two's complement with CODE_FRAC (default 8) fractional bits. Their sum is aligned to the estimate's 24 fractional bits. For channel A the residual is that sum minus est_a when `pn_a`=1 (meaning +1), or plus est_a when `pn_a`=0 (meaning -1). On a valid sample where residual times the calibration sign is positive, est_a rises by STEP (default 1 LSB = 2^-24).
- R4: On a valid sample where that product is negative, the estimate falls by STEP.
- R5: On a valid sample where the residual is exactly zero, the estimate holds.
- R6: Any value added to `code_a` and subtracted from `code_b` leaves both updates unchanged, because only the code sum enters the correlation.
- R7: Channel B forms its residual with `pn_b` and est_b by the same rule, independently of channel A's estimate.
- R8: `done` rises on the edge that accepts the 2^SAMPLE_LOG2-th valid sample since reset or restart. It then stays high, and the estimates keep updating.
- R9: A cycle with `restart`=1 clears `done` and the count at the next edge. A valid sample in that same cycle still updates the estimates but is not counted.
- R10: `pn_gen_a` is the MSB of a 15-bit Fibonacci register with feedback bit[14]^bit[13], shifted in at the LSB. `pn_gen_b` is the MSB of a 17-bit register with feedback bit[16]^bit[13]. Both are seeded with 1, and each advances once per valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Sample strobe for codes and calibration bits |
| restart | input | 1 | Clears sample count and completion flag |
| code_a | input | CODE_W | Channel A back-end code, signed |
| code_b | input | CODE_W | Channel B back-end code, signed |
| pn_a | input | 1 | Calibration bit aligned to code_a (1 = +1) |
| pn_b | input | 1 | Calibration bit aligned to code_b (1 = +1) |
| pn_gen_a | output | 1 | Generated calibration bit for channel A injection |
| pn_gen_b | output | 1 | Generated calibration bit for channel B injection |
| est_a | output | EST_W | Channel A radix estimate, signed fixed point |
| est_b | output | EST_W | Channel B radix estimate, signed fixed point |
| done | output | 1 | Configured number of valid samples processed |

## Verification
The following properties are checked on every cycle:
- Each estimate moves by at most one step per cycle.
- Both estimates freeze when no sample is offered.
- The completion flag is sticky until a restart, and a restart clears it.
- The flag only rises on an accepted sample.

The bench's scenarios cover the rest:
- The direction of each step for given code sums and calibration signs.
- The hold on an exactly zero residual.
- The insensitivity to a common-mode input split across the channels.
- The exact sample on which completion arrives.
- The generated bit sequences.

// File: rtl/radix_est_pkg.sv
package radix_est_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;
endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
    parameter int          WIDTH = 15,
    parameter logic [63:0] TAPS  = 64'h6000,
    parameter logic [63:0] SEED  = 64'h1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic bit_o
);
    logic [WIDTH-1:0] sr_d, sr_q;
    logic             fb;

    always_comb begin
        fb   = ^(sr_q & TAPS[WIDTH-1:0]);
        sr_d = sr_q;
        if (adv) begin
            sr_d = {sr_q[WIDTH-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= SEED[WIDTH-1:0];
        else        sr_q <= sr_d;
    end

    assign bit_o = sr_q[WIDTH-1];
endmodule

// File: rtl/radix_corr_step.sv
module radix_corr_step
    import radix_est_pkg::*;
#(
    parameter int EST_W = 32,
    parameter int SUM_W = 33
) (
    input  logic signed [SUM_W-1:0] sum_al,
    input  logic                    pn,
    input  logic signed [EST_W-1:0] est_q,
    output step_dir_e               dir
);
    localparam int RES_W = ((SUM_W > EST_W) ? SUM_W : EST_W) + 2;

    logic signed [RES_W-1:0] pterm, resid;

    always_comb begin
        pterm = pn ? RES_W'(est_q) : -RES_W'(est_q);
        resid = RES_W'(sum_al) - pterm;
        if (resid == '0)
            dir = DIR_HOLD;
        else if (resid[RES_W-1] != pn)
            dir = DIR_UP;
        else
            dir = DIR_DOWN;
    end
endmodule

// File: rtl/radix_corr_est.sv
module radix_corr_est
    import radix_est_pkg::*;
#(
    parameter int          CODE_W      = 16,
    parameter int          CODE_FRAC   = 8,
    parameter int          EST_W       = 32,
    parameter int          FRAC_W      = 24,
    parameter logic [31:0] INIT_EST    = 32'h0200_0000,
    parameter int          STEP        = 1,
    parameter int          SAMPLE_LOG2 = 20,
    parameter int          LFSR_A_W    = 15,
    parameter logic [63:0] LFSR_A_TAPS = 64'h6000,
    parameter int          LFSR_B_W    = 17,
    parameter logic [63:0] LFSR_B_TAPS = 64'h12000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  logic                     restart,
    input  logic signed [CODE_W-1:0] code_a,
    input  logic signed [CODE_W-1:0] code_b,
    input  logic                     pn_a,
    input  logic                     pn_b,
    output logic                     pn_gen_a,
    output logic                     pn_gen_b,
    output logic signed [EST_W-1:0]  est_a,
    output logic signed [EST_W-1:0]  est_b,
    output logic                     done
);
    localparam int NCH   = 2;
    localparam int SHIFT = FRAC_W - CODE_FRAC;
    localparam int SUM_W = CODE_W + 1 + SHIFT;
    localparam int CNT_W = SAMPLE_LOG2 + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(1) << SAMPLE_LOG2;
    localparam logic [EST_W-1:0] EST_MAX  = {1'b0, {(EST_W-1){1'b1}}};
    localparam logic [EST_W-1:0] EST_MIN  = {1'b1, {(EST_W-1){1'b0}}};

    typedef struct packed {
        logic [NCH-1:0][EST_W-1:0] est;
        logic [CNT_W-1:0]          cnt;
        logic                      done;
    } state_t;

    state_t s_d, s_q;

    logic signed [CODE_W:0]  code_sum;
    logic signed [SUM_W-1:0] sum_al;
    logic [NCH-1:0]          pn_in;
    step_dir_e               dir [NCH];

    assign code_sum = {code_a[CODE_W-1], code_a} + {code_b[CODE_W-1], code_b};
    assign sum_al   = {code_sum, {SHIFT{1'b0}}};
    assign pn_in    = {pn_b, pn_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        radix_corr_step #(
            .EST_W (EST_W),
            .SUM_W (SUM_W)
        ) u_step (
            .sum_al (sum_al),
            .pn     (pn_in[ch]),
            .est_q  ($signed(s_q.est[ch])),
            .dir    (dir[ch])
        );
    end

    always_comb begin
        s_d = s_q;
        if (valid) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (dir[ch] == DIR_UP && s_q.est[ch] != EST_MAX)
                    s_d.est[ch] = s_q.est[ch] + EST_W'(STEP);
                else if (dir[ch] == DIR_DOWN && s_q.est[ch] != EST_MIN)
                    s_d.est[ch] = s_q.est[ch] - EST_W'(STEP);
            end
        end
        if (restart) begin
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else if (valid && !s_q.done) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt + 1'b1 == CNT_FULL)
                s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.est  <= {NCH{INIT_EST[EST_W-1:0]}};
            s_q.cnt  <= '0;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    pn_lfsr #(.WIDTH(LFSR_A_W), .TAPS(LFSR_A_TAPS), .SEED(64'h1)) u_pn_a (
        .clk (clk), .rst_n (rst_n), .adv (valid), .bit_o (pn_gen_a)
    );
    pn_lfsr #(.WIDTH(LFSR_B_W), .TAPS(LFSR_B_TAPS), .SEED(64'h1)) u_pn_b (
        .clk (clk), .rst_n (rst_n), .adv (valid), .bit_o (pn_gen_b)
    );

    assign est_a = $signed(s_q.est[0]);
    assign est_b = $signed(s_q.est[1]);
    assign done  = s_q.done;
endmodule

// File: rtl/radix_corr_est_chk.sv
module radix_corr_est_chk #(
    parameter int EST_W = 32,
    parameter int STEP  = 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    valid,
    input logic                    restart,
    input logic signed [EST_W-1:0] est_a,
    input logic signed [EST_W-1:0] est_b,
    input logic                    done
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(est_a) && $stable(est_b)));

    // R3
    step_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (est_a == $past(est_a)) || (est_a - $past(est_a) == EST_W'(STEP))
                  || ($past(est_a) - est_a == EST_W'(STEP)));

    // R7
    step_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (est_b == $past(est_b)) || (est_b - $past(est_b) == EST_W'(STEP))
                  || ($past(est_b) - est_b == EST_W'(STEP)));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done);

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(valid));

    // R9
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done);
endmodule

bind radix_corr_est radix_corr_est_chk #(.EST_W(EST_W), .STEP(STEP)) u_chk (
    .clk (clk), .rst_n (rst_n), .valid (valid), .restart (restart),
    .est_a (est_a), .est_b (est_b), .done (done)
);

// File: tb/radix_corr_est_test.sv
module radix_corr_est_test;
    localparam int  LOG2 = 4;
    localparam int  NS   = 1 << LOG2;
    localparam logic signed [31:0] INIT = 32'sh0200_0000;

    logic clk = 0, rst_n = 0, valid = 0, restart = 0, pn_a = 0, pn_b = 0;
    logic signed [15:0] code_a = 0, code_b = 0;
    logic pn_gen_a, pn_gen_b, done;
    logic signed [31:0] est_a, est_b;

    int n_run = 0, n_fail = 0;
    logic signed [31:0] xa, xb;
    int cnt;

    always #4 clk = ~clk;

    radix_corr_est #(.SAMPLE_LOG2(LOG2)) uut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .restart(restart),
        .code_a(code_a), .code_b(code_b), .pn_a(pn_a), .pn_b(pn_b),
        .pn_gen_a(pn_gen_a), .pn_gen_b(pn_gen_b),
        .est_a(est_a), .est_b(est_b), .done(done)
    );

    // {valid, pn_a, pn_b, code_a, code_b, delta_a, delta_b}
    localparam logic [38:0] VECS [0:7] = '{
        {1'b1, 1'b1, 1'b1,  16'sd740,   -16'sd100,  2'b01, 2'b01},
        {1'b1, 1'b0, 1'b1, -16'sd340,   -16'sd300,  2'b01, 2'b11},
        {1'b1, 1'b1, 1'b0, -16'sd1600,  16'sd2000,  2'b11, 2'b11},
        {1'b0, 1'b1, 1'b1,  16'sd1000,  16'sd1000,  2'b00, 2'b00},
        {1'b1, 1'b0, 1'b0,  16'sd4000, -16'sd5000,  2'b01, 2'b01},
        {1'b1, 1'b1, 1'b1,  16'sd7,    -16'sd7,     2'b11, 2'b11},
        {1'b1, 1'b0, 1'b1, -16'sd1200,  16'sd1800,  2'b11, 2'b01},
        {1'b0, 1'b0, 1'b0, -16'sd9000,  16'sd3,     2'b00, 2'b00}
    };

    task automatic chk(input string req, input logic signed [63:0] act, input logic signed [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic r, input logic pa, input logic pb,
                        input logic signed [15:0] ca, input logic signed [15:0] cb);
        @(negedge clk);
        valid = v; restart = r; pn_a = pa; pn_b = pb; code_a = ca; code_b = cb;
        @(negedge clk);
        valid = 0; restart = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic pga, pgb;
        logic [14:0] ma;
        logic [16:0] mb;
        do_reset();
        // R1 reset state
        chk("R1 est_a", est_a, INIT);
        chk("R1 est_b", est_b, INIT);
        chk("R1 done", done, 0);
        chk("R1 pn_gen_a", pn_gen_a, 0);
        chk("R1 pn_gen_b", pn_gen_b, 0);
        xa = INIT; xb = INIT; cnt = 0;

        // R5 zero residual: sum = +2.0 with +1 signs, then -2.0 with -1 signs
        step(1, 0, 1, 1, 16'sd521, -16'sd9); cnt++;
        chk("R5 est_a hold +", est_a, xa);
        chk("R5 est_b hold +", est_b, xb);
        step(1, 0, 0, 0, -16'sd500, -16'sd12); cnt++;
        chk("R5 est_a hold -", est_a, xa);
        chk("R5 est_b hold -", est_b, xb);

        // R3 R4 R6 R7 R2 vector table
        for (int i = 0; i < 8; i++) begin
            logic [38:0] e;
            e = VECS[i];
            pga = pn_gen_a; pgb = pn_gen_b;
            step(e[38], 0, e[37], e[36], e[35:20], e[19:4]);
            xa = xa + 32'($signed(e[3:2]));
            xb = xb + 32'($signed(e[1:0]));
            if (e[38]) cnt++;
            chk("R3/R4/R6 est_a vector", est_a, xa);
            chk("R7 est_b vector", est_b, xb);
            if (!e[38]) begin
                chk("R2 pn_gen_a held", pn_gen_a, pga);
                chk("R2 pn_gen_b held", pn_gen_b, pgb);
            end
        end

        // R8 completion after exactly NS valid samples
        while (cnt < NS - 1) begin
            step(1, 0, 1, 1, 16'sd640, 16'sd0); cnt++; xa++; xb++;
        end
        chk("R8 done low before last sample", done, 0);
        step(1, 0, 1, 1, 16'sd640, 16'sd0); xa++; xb++;
        chk("R8 done on last sample", done, 1);
        step(1, 0, 1, 1, 16'sd640, 16'sd0); xa++; xb++;
        chk("R8 done sticky", done, 1);
        chk("R8 est_a keeps tracking", est_a, xa);
        chk("R8 est_b keeps tracking", est_b, xb);

        // R9 restart with a valid sample in the same cycle
        step(1, 1, 1, 1, 16'sd640, 16'sd0); xa++; xb++;
        chk("R9 done cleared", done, 0);
        chk("R9 est_a updated during restart", est_a, xa);
        for (int k = 0; k < NS - 1; k++) begin
            step(1, 0, 1, 1, 16'sd640, 16'sd0); xa++; xb++;
        end
        chk("R9 not done one short", done, 0);
        step(1, 0, 1, 1, 16'sd640, 16'sd0); xa++; xb++;
        chk("R9 done after recount", done, 1);

        // R10 generated sequences
        do_reset();
        ma = 15'd1; mb = 17'd1;
        for (int k = 0; k < 40; k++) begin
            chk("R10 pn_gen_a", pn_gen_a, ma[14]);
            chk("R10 pn_gen_b", pn_gen_b, mb[16]);
            if (k % 5 == 3) begin
                step(0, 0, 0, 0, 16'sd0, 16'sd0);
            end else begin
                step(1, 0, 0, 0, 16'sd0, 16'sd0);
                ma = {ma[13:0], ma[14] ^ ma[13]};
                mb = {mb[15:0], mb[16] ^ mb[13]};
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule